// File: doc/BRIEF.md
# Equalizer Band Control Slave

This block is the serial control front end of a stereo five-band boost/cut equalizer. It listens on a two-wire serial bus (I2C, write transfers only) and accepts writes from a bus master. A transfer carries a slave address, then a register index, then one or more data bytes. Each band register holds a 3-bit boost code and a 3-bit cut code. The first register also carries a defeat flag that bypasses all filtering.

SCL and SDA are sampled with the system clock through two-flop synchronizers. START and STOP conditions are found from SDA edges while SCL is high. Every accepted byte is acknowledged by pulling SDA low through an open-drain enable. One input pin picks one of two slave addresses. After each data byte the register index advances by one. The block decodes the stored codes into boost and cut steps from 0 to 5 for each band. One set of decoded outputs feeds both audio channels, so left and right always get identical settings.

Top module: `eq_ctrl_slave`

## Requirements
- R1: The slave answers the 8-bit address byte 0x84 when `addr_pin` is 0 and 0x86 when `addr_pin` is 1. Bit 0 of this byte is the read/write bit, and 0 means write. A byte with the other address gets no acknowledge.
- R2: The slave acknowledges each accepted byte (address, index and every data byte) by asserting `sda_pull_low` during the ninth SCL clock. It changes `sda_pull_low` only while SCL is low.
- R3: Each data byte after the index byte is written to the current index, and the index then increases by one. Several bytes in one transfer therefore fill consecutive registers.
- R4: Index values 0 to 4 select the registers for bands 1 to 5. In each register, bits 6:4 hold the boost code and bits 2:0 hold the cut code. Bit 7 of register 0 is the defeat flag. Band k drives bits [3k-1:3k-3] of `boost_step` and `cut_step`. The outputs change only after a data byte is written.
- R5: Codes 0 to 4 decode to steps 0 to 4. Codes 5, 6 and 7 all decode to step 5.
- R6: While the defeat flag is 1, every boost and cut output is 0. The stored codes are kept and appear again once the flag is cleared.
- R7: Reset sets the defeat flag, clears all band codes, releases SDA and returns the bus receiver to idle.
- R8: An address byte with the read/write bit set to 1, or with no address match, gets no acknowledge. The bytes that follow get no acknowledge and change nothing until the next START.
- R9: A data byte written at an index above 4 is acknowledged and discarded. The index stops at 255 and never wraps back to a band register.
- R10: A repeated START in the middle of a transfer returns the receiver to the address phase. The next transfer is then handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| addr_pin | input | 1 | Selects the slave address: 0 for 0x84, 1 for 0x86 |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| boost_step | output | 15 | Decoded boost step per band, 3 bits each |
| cut_step | output | 15 | Decoded cut step per band, 3 bits each |
| defeat | output | 1 | Stored defeat flag |

## Verification
A multi-byte write through all five bands uses codes from the low range, the edge code 4 and the saturating codes 5 to 7. This separates correct decoding from a plain copy of the code and checks that the index advances. Transfers with the wrong address, with the read bit set, with an index above 4 and with an index stuck at 255 must all leave the outputs unchanged, while the acknowledge pattern tells the ignored cases from the discarded ones. Setting and clearing defeat around stored values, a repeated START in the middle of a transfer, the second address pin setting and a reset in the middle of a run each show a separate way a transfer can be lost or a setting forgotten.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

  localparam int STEP_W   = 3;
  localparam int REG_W    = 8;
  localparam int BOOST_LO = 4;
  localparam int CUT_LO   = 0;
  localparam int DEF_BIT  = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_DATA,
    PH_SKIP
  } phase_t;

  function automatic logic [STEP_W-1:0] step_sat(input logic [STEP_W-1:0] code);
    return (code > 3'd4) ? 3'd5 : code;
  endfunction

endpackage

// File: rtl/eqs_line_sync.sv
module eqs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES:0] scl_sh_q, scl_sh_d;
  logic [STAGES:0] sda_sh_q, sda_sh_d;
  logic scl_prev, sda_prev;

  always_comb begin
    scl_sh_d = {scl_sh_q[STAGES-1:0], scl_in};
    sda_sh_d = {sda_sh_q[STAGES-1:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign scl_prev  = scl_sh_q[STAGES];
  assign sda_prev  = sda_sh_q[STAGES];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/eqs_byte_engine.sv
module eqs_byte_engine
  import eqs_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h42,
  parameter int         NBANDS    = 5,
  localparam int        IDX_W     = $clog2(NBANDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic             addr_pin,
  output logic             ack_drive,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  phase_t     phase_q, phase_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] shift_q, shift_d;
  logic [7:0] index_q, index_d;
  logic       ack_q, ack_d;
  logic       in_byte, byte_ok, idx_valid;

  assign in_byte   = (phase_q == PH_ADDR) || (phase_q == PH_INDEX) || (phase_q == PH_DATA);
  assign idx_valid = (index_q < 8'(NBANDS));
  assign byte_ok   = (phase_q != PH_ADDR) ||
                     ((shift_q[7:1] == {ADDR_BASE[6:1], addr_pin}) && !shift_q[0]);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    index_d = index_q;
    ack_d   = ack_q;
    wr_en   = 1'b0;
    if (start_det) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (in_byte) begin
      if (scl_rise && cnt_q < 4'd8) begin
        shift_d = {shift_q[6:0], sda_s};
        cnt_d   = cnt_q + 4'd1;
      end else if (scl_fall && cnt_q == 4'd8) begin
        if (byte_ok) begin
          ack_d = 1'b1;
          cnt_d = 4'd9;
          if (phase_q == PH_INDEX) index_d = shift_q;
          if (phase_q == PH_DATA) begin
            wr_en   = idx_valid;
            index_d = (index_q == 8'hFF) ? index_q : index_q + 8'd1;
          end
        end else begin
          phase_d = PH_SKIP;
          cnt_d   = '0;
        end
      end else if (scl_fall && cnt_q == 4'd9) begin
        ack_d = 1'b0;
        cnt_d = '0;
        phase_d = (phase_q == PH_ADDR) ? PH_INDEX : PH_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      index_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      index_q <= index_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_drive = ack_q;
  assign wr_idx    = index_q[IDX_W-1:0];
  assign wr_data   = shift_q;

endmodule

// File: rtl/eqs_reg_bank.sv
module eqs_reg_bank
  import eqs_pkg::*;
#(
  parameter int NBANDS = 5,
  localparam int IDX_W = $clog2(NBANDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [REG_W-1:0]        wr_data,
  output logic [NBANDS*REG_W-1:0] regs_flat
);

  localparam logic [REG_W-1:0] FIRST_INIT = REG_W'(1) << DEF_BIT;

  logic [REG_W-1:0] regs_q [NBANDS];
  logic [REG_W-1:0] regs_d [NBANDS];

  always_comb begin
    for (int i = 0; i < NBANDS; i++) regs_d[i] = regs_q[i];
    if (wr_en && (32'(wr_idx) < NBANDS)) regs_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANDS; i++) regs_q[i] <= (i == 0) ? FIRST_INIT : '0;
    end else begin
      for (int i = 0; i < NBANDS; i++) regs_q[i] <= regs_d[i];
    end
  end

  for (genvar g = 0; g < NBANDS; g++) begin : g_flat
    assign regs_flat[g*REG_W +: REG_W] = regs_q[g];
  end

endmodule

// File: rtl/eqs_step_decode.sv
module eqs_step_decode
  import eqs_pkg::*;
#(
  parameter int NBANDS = 5
) (
  input  logic [NBANDS*REG_W-1:0]  regs_flat,
  output logic [NBANDS*STEP_W-1:0] boost_step,
  output logic [NBANDS*STEP_W-1:0] cut_step,
  output logic                     defeat
);

  assign defeat = regs_flat[DEF_BIT];

  for (genvar b = 0; b < NBANDS; b++) begin : g_band
    assign boost_step[b*STEP_W +: STEP_W] =
      defeat ? '0 : step_sat(regs_flat[b*REG_W + BOOST_LO +: STEP_W]);
    assign cut_step[b*STEP_W +: STEP_W] =
      defeat ? '0 : step_sat(regs_flat[b*REG_W + CUT_LO +: STEP_W]);
  end

endmodule

// File: rtl/eq_ctrl_slave.sv
module eq_ctrl_slave #(
  parameter int         NBANDS      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h42,
  localparam int        STEP_W      = eqs_pkg::STEP_W,
  localparam int        REG_W       = eqs_pkg::REG_W,
  localparam int        IDX_W       = $clog2(NBANDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  input  logic                     addr_pin,
  output logic                     sda_pull_low,
  output logic [NBANDS*STEP_W-1:0] boost_step,
  output logic [NBANDS*STEP_W-1:0] cut_step,
  output logic                     defeat
);

  logic [1:0]              rst_pipe_q;
  logic                    rst_sync_n;
  logic                    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                    wr_en;
  logic [IDX_W-1:0]        wr_idx;
  logic [REG_W-1:0]        wr_data;
  logic [NBANDS*REG_W-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  eqs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eqs_byte_engine #(.ADDR_BASE(ADDR_BASE), .NBANDS(NBANDS)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_pin(addr_pin), .ack_drive(sda_pull_low), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  eqs_reg_bank #(.NBANDS(NBANDS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  eqs_step_decode #(.NBANDS(NBANDS)) u_decode (
    .regs_flat(regs_flat), .boost_step(boost_step), .cut_step(cut_step),
    .defeat(defeat)
  );

endmodule

// File: rtl/eqs_checker.sv
module eqs_checker #(
  parameter int NBANDS = 5,
  localparam int SW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_pull_low,
  input logic               wr_en,
  input logic [NBANDS*SW-1:0] boost_step,
  input logic [NBANDS*SW-1:0] cut_step,
  input logic               defeat
);

  // R2: the acknowledge drive only moves while the synchronized SCL is low
  assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_low != $past(sda_pull_low)) |-> !scl_s);

  // R4: the decoded settings move only in the cycle after a register write
  assert_hold_unless_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(boost_step) && $stable(cut_step) && $stable(defeat)));

  // R6: defeat forces every step to zero
  assert_defeat_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    defeat |-> (boost_step == '0 && cut_step == '0));

  // R5: no decoded step ever exceeds 5
  for (genvar b = 0; b < NBANDS; b++) begin : g_rng
    assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boost_step[b*SW +: SW] <= 3'd5) && (cut_step[b*SW +: SW] <= 3'd5));
  end

endmodule

bind eq_ctrl_slave eqs_checker #(.NBANDS(NBANDS)) u_checker (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_pull_low(sda_pull_low),
  .wr_en(wr_en), .boost_step(boost_step), .cut_step(cut_step), .defeat(defeat)
);

// File: tb/test_eq_ctrl_slave.sv
module test_eq_ctrl_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WATCHDOG   = 150000;

  localparam int K_ACK = 0, K_BOOST = 1, K_CUT = 2, K_DEF = 3, K_SDA = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_pin = 1'b0;
  logic        sda_bus;
  logic        sda_pull_low;
  logic [14:0] boost_step, cut_step;
  logic        defeat;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t sb_q[$];
  item_t it;
  logic [31:0] act;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_low;

  eq_ctrl_slave i_eq_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_pin(addr_pin), .sda_pull_low(sda_pull_low),
    .boost_step(boost_step), .cut_step(cut_step), .defeat(defeat)
  );

  // monitor: pop expected items and compare against the ports
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        K_ACK:   act = {31'd0, sda_pull_low};
        K_BOOST: act = {17'd0, boost_step};
        K_CUT:   act = {17'd0, cut_step};
        K_DEF:   act = {31'd0, defeat};
        default: act = {31'd0, sda_pull_low};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    item_t n;
    n.kind = kind; n.exp = exp; n.req = req;
    sb_q.push_back(n);
  endtask

  task automatic wait_q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  function automatic logic [14:0] pk(input int s1, s2, s3, s4, s5);
    return {3'(s5), 3'(s4), 3'(s3), 3'(s2), 3'(s1)};
  endfunction

  task automatic expect_cfg(input logic [14:0] b, input logic [14:0] c,
                            input logic d, input string req);
    push(K_BOOST, {17'd0, b}, req);
    push(K_CUT, {17'd0, c}, req);
    push(K_DEF, {31'd0, d}, req);
    push(K_SDA, 32'd0, req);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    push(K_ACK, {31'd0, exp_ack}, req);
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: state while reset is held
    repeat (4) @(posedge clk); #1;
    expect_cfg(15'd0, 15'd0, 1'b1, "R7 reset");
    rst_n = 1'b1;
    repeat (10) @(posedge clk); #1;
    expect_cfg(15'd0, 15'd0, 1'b1, "R7 after release");

    // R1 R2 R3 R4 R5 R9: burst through all bands and past the end
    bus_start();
    send_byte(8'h84, 1'b1, "R1 addr low pin");
    send_byte(8'h00, 1'b1, "R2 index ack");
    send_byte(8'h00, 1'b1, "R2 data ack");
    send_byte(8'h25, 1'b1, "R3 band2");
    send_byte(8'h47, 1'b1, "R3 band3");
    send_byte(8'h61, 1'b1, "R3 band4");
    send_byte(8'h33, 1'b1, "R3 band5");
    send_byte(8'hAA, 1'b1, "R9 index 5 ack");
    send_byte(8'h12, 1'b1, "R9 index 6 ack");
    bus_stop();
    expect_cfg(pk(0,2,4,5,3), pk(0,5,5,1,3), 1'b0, "R5 R4 burst decode");

    // R1 R8: wrong address, then trailing bytes ignored
    bus_start();
    send_byte(8'h86, 1'b0, "R1 wrong addr nack");
    send_byte(8'h00, 1'b0, "R8 ignored byte");
    send_byte(8'h13, 1'b0, "R8 ignored byte");
    bus_stop();
    expect_cfg(pk(0,2,4,5,3), pk(0,5,5,1,3), 1'b0, "R8 unchanged");

    // R8: read bit set
    bus_start();
    send_byte(8'h85, 1'b0, "R8 read nack");
    send_byte(8'h00, 1'b0, "R8 after read");
    bus_stop();
    expect_cfg(pk(0,2,4,5,3), pk(0,5,5,1,3), 1'b0, "R8 read unchanged");

    // R6: defeat on with new band1 codes, then off
    bus_start();
    send_byte(8'h84, 1'b1, "R6 addr");
    send_byte(8'h00, 1'b1, "R6 index");
    send_byte(8'hD2, 1'b1, "R6 data");
    bus_stop();
    expect_cfg(15'd0, 15'd0, 1'b1, "R6 defeat forces zero");
    bus_start();
    send_byte(8'h84, 1'b1, "R6 addr");
    send_byte(8'h00, 1'b1, "R6 index");
    send_byte(8'h52, 1'b1, "R6 data");
    bus_stop();
    expect_cfg(pk(5,2,4,5,3), pk(2,5,5,1,3), 1'b0, "R6 stored kept");

    // R10: repeated start mid transfer
    bus_start();
    send_byte(8'h84, 1'b1, "R10 addr");
    send_byte(8'h03, 1'b1, "R10 index");
    send_byte(8'h00, 1'b1, "R10 data");
    bus_start();
    send_byte(8'h84, 1'b1, "R10 addr after restart");
    send_byte(8'h01, 1'b1, "R10 index");
    send_byte(8'h70, 1'b1, "R10 data");
    bus_stop();
    expect_cfg(pk(5,5,4,0,3), pk(2,0,5,0,3), 1'b0, "R10 restart writes");

    // R9: high index and saturation at 255
    bus_start();
    send_byte(8'h84, 1'b1, "R9 addr");
    send_byte(8'h07, 1'b1, "R9 index 7");
    send_byte(8'h55, 1'b1, "R9 discard");
    bus_stop();
    bus_start();
    send_byte(8'h84, 1'b1, "R9 addr");
    send_byte(8'hFF, 1'b1, "R9 index 255");
    send_byte(8'h11, 1'b1, "R9 discard at 255");
    send_byte(8'h22, 1'b1, "R9 no wrap");
    bus_stop();
    expect_cfg(pk(5,5,4,0,3), pk(2,0,5,0,3), 1'b0, "R9 unchanged");

    // R1: address pin high
    addr_pin = 1'b1;
    wait_q();
    bus_start();
    send_byte(8'h84, 1'b0, "R1 low addr with pin high");
    bus_stop();
    bus_start();
    send_byte(8'h86, 1'b1, "R1 high addr");
    send_byte(8'h04, 1'b1, "R1 index");
    send_byte(8'h44, 1'b1, "R1 data");
    bus_stop();
    expect_cfg(pk(5,5,4,0,4), pk(2,0,5,0,4), 1'b0, "R1 pin high write");

    // R7: reset in the middle of a run
    rst_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    expect_cfg(15'd0, 15'd0, 1'b1, "R7 mid reset");
    rst_n = 1'b1;
    repeat (10) @(posedge clk); #1;
    bus_start();
    send_byte(8'h86, 1'b1, "R7 addr");
    send_byte(8'h00, 1'b1, "R7 index");
    send_byte(8'h00, 1'b1, "R7 data");
    bus_stop();
    expect_cfg(15'd0, 15'd0, 1'b0, "R7 codes cleared");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule